// File: doc/BRIEF.md
# Bias DAC Serial Writer (register-toggled two-wire)

This block sends one three-byte write to a serial bias DAC over a two-wire link that looks like I2C. It does not own any pins. The two wires are bits of a power-control register: the clock wire is bit 0 and the data wire is bit 1. The block changes a wire by issuing a complete register write through a valid/ready request port. Every register bit above the two wires keeps the base pattern that the caller supplies, for the whole transaction.

A one-cycle `start` pulse captures the value byte and the base pattern. The block then emits a start condition and three bytes, most significant bit first: a fixed address byte 0x9C, a fixed sub-address 0x00, and the captured value. Each byte is followed by a blind acknowledge slot. A stop condition closes the transaction.

The link is write-only, so the acknowledge slot is one more clock period with data low, and nothing is sampled in it. After a register write has been accepted, the next one waits for a settle time. That time is derived from the clock-frequency parameter and must be at least 10 µs of wall time. `done` pulses when the transaction is over.

Top module: `dacw_writer`

## Requirements
- R1: Throughout reset and in the first cycle after reset is released, `wr_valid` and `done` are 0.
- R2: Every request carries `wr_addr` = REG_ADDR (3 by default). `wr_data[7:2]` equals `base[7:2]` as captured at the accepted start pulse. Only bit 0 (clock wire) and bit 1 (data wire) vary.
- R3: The first three accepted writes of a transaction form the start condition. Their bits [1:0] are 2'b11, then 2'b01, then 2'b00.
- R4: Each data bit takes three writes with the data wire (bit 1) held at the bit's value and the clock wire (bit 0) going 0, 1, 0. The bits of each byte go out most significant first.
- R5: The bytes are sent in the order 0x9C, 0x00, then the captured value. Each byte is followed by an acknowledge slot of three writes with data 0 and clock 0, 1, 0. A transaction is exactly 87 accepted writes.
- R6: The last three accepted writes form the stop condition. Their bits [1:0] are 2'b00, then 2'b01, then 2'b11.
- R7: A start pulse in the idle state raises `wr_valid` in the next cycle. After any accepted write, `wr_valid` stays low for exactly SETTLE cycles before the next request. SETTLE = ceil(CLK_HZ·SETTLE_NS/10^9).
- R8: While `wr_valid` is high and `wr_ready` is low, the request stays asserted and `wr_addr` and `wr_data` do not change.
- R9: `done` is high for exactly one cycle, which is the cycle after the final stop write is accepted. It is never high at any other time.
- R10: A start pulse has no effect while a transaction is in progress, or while the settle time after its final write is running. It does not change the data sent and does not cause any further writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a transaction |
| value | input | 8 | DAC value byte, captured at start |
| base | input | 8 | Pattern for the non-wire register bits, captured at start |
| wr_valid | output | 1 | Register write request pending |
| wr_ready | input | 1 | Register write accepted when high with `wr_valid` |
| wr_addr | output | 8 | Register address of the request |
| wr_data | output | 8 | Register data of the request |
| done | output | 1 | One-cycle pulse after the final write is accepted |

## Verification
A wrong counter in the step sequencer shows up in the bit pair of a specific accepted write, counted from the start of the transaction. Such an error is also visible as a total write count other than 87 or as a missing or early `done`. A fault in the settle timer changes the number of low cycles on `wr_valid` between two writes, so it appears at the first gap after the fault. A capture or busy fault shows up either as wrong upper data bits or as a wrong value byte. It can also show as a write request appearing after a start pulse that should have been ignored.

// File: rtl/dacw_pkg.sv
// Shared types for the bias DAC serial writer.
// Assumes: the two wire bits sit at positions 1 (data) and 0 (clock).
package dacw_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_WAIT} fsm_t;
    typedef enum logic [1:0] {SEG_START, SEG_BODY, SEG_STOP} seg_t;
    typedef struct packed {
        logic dat;
        logic clk;
    } wire_t;
endpackage

// File: rtl/dacw_settle_timer.sv
// Settle timer: once loaded, it counts CYCLES cycles and raises `last` in
// the final one. Assumes CYCLES >= 1 and that load never arrives while
// the timer is still counting.
module dacw_settle_timer #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic last
);
    localparam int W = (CYCLES < 2) ? 1 : $clog2(CYCLES);

    logic [W-1:0] cnt;
    logic         active;

    // Down-counter that runs from CYCLES-1 to zero after each load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (load) begin
            active <= 1'b1;
            cnt    <= W'(CYCLES - 1);
        end else if (active) begin
            if (cnt == '0) active <= 1'b0;
            else           cnt    <= cnt - 1'b1;
        end
    end

    assign last = active && (cnt == '0);
endmodule

// File: rtl/dacw_step_gen.sv
// Wire step generator: walks start, data and acknowledge bits, then stop,
// and gives the clock and data wire levels for the current register write.
// Assumes `advance` pulses once per accepted write, and that `clear`
// arrives only between transactions.
module dacw_step_gen
    import dacw_pkg::*;
#(
    parameter int                       DW     = 8,
    parameter int                       NBYTES = 3,
    parameter logic [(NBYTES-1)*DW-1:0] HDR    = 16'h9C00
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          advance,
    input  logic [DW-1:0] value_q,
    output wire_t         lvl,
    output logic          last
);
    localparam int PW = $clog2(DW + 1);
    localparam int BW = (NBYTES < 2) ? 1 : $clog2(NBYTES);

    seg_t          seg;
    logic [1:0]    sub;
    logic [PW-1:0] pos;
    logic [BW-1:0] bidx;
    logic [DW-1:0] cur_byte;

    // Nested counters: sub-step, then bit slot, then byte, then segment.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            seg  <= SEG_START;
            sub  <= '0;
            pos  <= '0;
            bidx <= '0;
        end else if (advance) begin
            if (sub != 2'd2) begin
                sub <= sub + 2'd1;
            end else begin
                sub <= '0;
                unique case (seg)
                    SEG_START: seg <= SEG_BODY;
                    SEG_BODY: begin
                        if (pos == PW'(DW)) begin
                            pos <= '0;
                            if (bidx == BW'(NBYTES - 1)) seg <= SEG_STOP;
                            else                         bidx <= bidx + 1'b1;
                        end else begin
                            pos <= pos + 1'b1;
                        end
                    end
                    default: seg <= SEG_STOP;
                endcase
            end
        end
    end

    // Byte selection: the fixed header bytes first, the caller's value last.
    always_comb begin
        if (bidx == BW'(NBYTES - 1)) cur_byte = value_q;
        else cur_byte = HDR[(NBYTES - 2 - int'(bidx)) * DW +: DW];
    end

    // Wire levels for the present sub-step.
    always_comb begin
        unique case (seg)
            SEG_START: begin
                lvl.clk = (sub != 2'd2);
                lvl.dat = (sub == 2'd0);
            end
            SEG_BODY: begin
                lvl.clk = (sub == 2'd1);
                lvl.dat = (pos == PW'(DW)) ? 1'b0 : cur_byte[DW - 1 - int'(pos)];
            end
            default: begin
                lvl.clk = (sub != 2'd0);
                lvl.dat = (sub == 2'd2);
            end
        endcase
    end

    assign last = (seg == SEG_STOP) && (sub == 2'd2);

    // R4: the data wire does not move inside a bit period.
    p_dat_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !clear && seg == SEG_BODY && sub != 2'd2) |=> $stable(lvl.dat));
    // R4: the clock-high write of a bit is followed by a clock-low write.
    p_clk_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !clear && seg == SEG_BODY && lvl.clk) |=> !lvl.clk);
endmodule

// File: rtl/dacw_writer.sv
// Bias DAC serial writer, top level. It turns one start pulse into the
// register writes that toggle the clock and data wire bits of a power
// register, with a settle gap after every accepted write. Assumes that the
// consumer of the request port keeps wr_ready independent of wr_valid.
module dacw_writer
    import dacw_pkg::*;
#(
    parameter int          CLK_HZ    = 100_000_000,
    parameter int          SETTLE_NS = 10_000,
    parameter int          DW        = 8,
    parameter int          ADDR_W    = 8,
    parameter int          REG_ADDR  = 3,
    parameter logic [15:0] HDR       = 16'h9C00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DW-1:0]     value,
    input  logic [DW-1:0]     base,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DW-1:0]     wr_data,
    output logic              done
);
    localparam longint PROD   = longint'(CLK_HZ) * longint'(SETTLE_NS);
    localparam longint RAW    = (PROD + 64'd999_999_999) / 64'd1_000_000_000;
    localparam int     SETTLE = (RAW < 1) ? 1 : int'(RAW);

    fsm_t          state;
    logic [DW-1:0] value_q;
    logic [DW-1:0] base_q;
    logic          last_q;
    logic          accept;
    logic          go;
    logic          tmr_last;
    logic          step_last;
    wire_t         lvl;

    assign accept = wr_valid && wr_ready;
    assign go     = start && (state == ST_IDLE);

    dacw_step_gen #(.DW(DW), .NBYTES(3), .HDR(HDR)) u_step (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (go),
        .advance (accept),
        .value_q (value_q),
        .lvl     (lvl),
        .last    (step_last)
    );

    dacw_settle_timer #(.CYCLES(SETTLE)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .last  (tmr_last)
    );

    // Capture the value and base once per transaction; ignore starts while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q <= '0;
            base_q  <= '0;
        end else if (go) begin
            value_q <= value;
            base_q  <= base;
        end
    end

    // Sequencing: request, wait for acceptance, settle, repeat until stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            last_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (go) state <= ST_SEND;
                ST_SEND: if (accept) begin
                    state  <= ST_WAIT;
                    last_q <= step_last;
                end
                default: if (tmr_last) state <= last_q ? ST_IDLE : ST_SEND;
            endcase
        end
    end

    // Completion pulse in the cycle after the stop write is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= accept && step_last;
    end

    assign wr_valid = (state == ST_SEND);
    assign wr_addr  = ADDR_W'(REG_ADDR);
    assign wr_data  = {base_q[DW-1:2], lvl.dat, lvl.clk};

    // R8: a stalled request holds its address and data.
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_addr)));
    // R7: an accepted write is followed by a settle gap.
    p_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !wr_valid);
    // R9: done follows an accepted write and lasts a single cycle.
    p_done_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(accept));
    p_done_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10: a start while busy leaves the captured value untouched.
    p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state != ST_IDLE) |=> $stable(value_q) && $stable(base_q));
endmodule

// File: tb/tb_dacw_writer.sv
module tb_dacw_writer;
    localparam int S = 100;   // 10 MHz, 10 us

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] value = '0;
    logic [7:0] base = '0;
    logic       wr_valid;
    logic       wr_ready = 1'b1;
    logic [7:0] wr_addr;
    logic [7:0] wr_data;
    logic       done;

    int checks = 0;
    int fails = 0;
    int wcnt = 0;
    int total = 0;
    int gap = 0;
    int dones = 0;
    bit prev_valid = 0;
    bit prev_ready = 0;
    bit prev_acc_last = 0;
    logic [7:0] prev_data = '0;
    logic [7:0] exp_val = '0;
    logic [7:0] exp_base = '0;
    int unsigned seed_init;

    dacw_writer #(.CLK_HZ(10_000_000), .SETTLE_NS(10_000)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .value(value), .base(base),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_data(wr_data), .done(done)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h (write %0d)", req, act, exp, wcnt);
        end
    endtask

    // Expected {data,clock} wire pair for write number idx of a transaction.
    function automatic logic [1:0] exp_bits(input int idx, input logic [7:0] v);
        int k, per, sub, byt, pos;
        logic [7:0] b;
        logic d;
        if (idx < 3) return (idx == 0) ? 2'b11 : (idx == 1) ? 2'b01 : 2'b00;
        if (idx >= 84) return (idx == 84) ? 2'b00 : (idx == 85) ? 2'b01 : 2'b11;
        k   = idx - 3;
        per = k / 3;
        sub = k % 3;
        byt = per / 9;
        pos = per % 9;
        b   = (byt == 0) ? 8'h9C : (byt == 1) ? 8'h00 : v;
        d   = (pos == 8) ? 1'b0 : b[7 - pos];
        return {d, (sub == 1)};
    endfunction

    function automatic string region(input int idx);
        if (idx < 3) return "R3";
        if (idx >= 84) return "R6";
        if (((idx - 3) / 3) % 9 == 8) return "R5";
        return "R4";
    endfunction

    // Monitor of the request port, sampled at the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_valid && !prev_ready)
                chk(wr_valid && wr_data == prev_data, "R8", wr_data, prev_data);
            if (done || prev_acc_last)
                chk(done == prev_acc_last, "R9", done, prev_acc_last);
            if (done) dones++;
            if (wr_valid && !prev_valid && wcnt > 0)
                chk(gap == S, "R7", gap, S);
            if (!wr_valid) gap++;
            prev_acc_last = wr_valid && wr_ready && (wcnt == 86);
            if (wr_valid && wr_ready) begin
                chk(wr_addr == 8'd3, "R2", wr_addr, 3);
                chk(wr_data[7:2] == exp_base[7:2], "R2", wr_data[7:2], exp_base[7:2]);
                if (wcnt < 87)
                    chk(wr_data[1:0] == exp_bits(wcnt, exp_val), region(wcnt),
                        wr_data[1:0], exp_bits(wcnt, exp_val));
                else
                    chk(1'b0, "R5", wcnt, 86);
                wcnt++;
                total++;
                gap = 0;
            end
            prev_valid = wr_valid;
            prev_ready = wr_ready;
            prev_data  = wr_data;
        end
    end

    task automatic pulse_start(input logic [7:0] v, input logic [7:0] b);
        start = 1'b1;
        value = v;
        base  = b;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_txn(input logic [7:0] v, input logic [7:0] b, input bit poke);
        int d0, guard;
        exp_val  = v;
        exp_base = b;
        wcnt     = 0;
        d0       = dones;
        pulse_start(v, b);
        chk(wr_valid, "R7", wr_valid, 1);   // request the cycle after start
        guard = 0;
        while (dones == d0 && guard < 30000) begin
            @(negedge clk);
            guard++;
            if (poke && wcnt == 40 && !start)
                pulse_start(~v, ~b);          // R10: ignored mid-transaction
        end
        chk(wcnt == 87, "R5", wcnt, 87);
        repeat (S + 3) @(negedge clk);
    endtask

    initial begin
        int t0;
        seed_init = $urandom(32'h0000_5EED);
        repeat (3) @(negedge clk);
        chk(wr_valid == 1'b0 && done == 1'b0, "R1", {wr_valid, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(wr_valid == 1'b0 && done == 1'b0, "R1", {wr_valid, done}, 0);
        // Directed corner cases.
        run_txn(8'h00, 8'hFF, 1'b0);
        run_txn(8'hFF, 8'h00, 1'b1);
        // R10: start during the settle after the final write.
        exp_val = 8'hA5; exp_base = 8'h5A; wcnt = 0;
        pulse_start(8'hA5, 8'h5A);
        while (wcnt < 87) @(negedge clk);
        repeat (5) @(negedge clk);
        t0 = total;
        pulse_start(8'h33, 8'hCC);
        repeat (300) @(negedge clk);
        chk(total == t0, "R10", total - t0, 0);
        // Random transactions.
        for (int i = 0; i < 3; i++)
            run_txn(8'($urandom), 8'($urandom), 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Random back-pressure on the request port.
    initial begin
        forever begin
            @(negedge clk);
            wr_ready = ($urandom % 4) != 0;
        end
    end

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule